// File: doc/BRIEF.md
# Single-Cycle Unsigned Integer Divider

This block divides an unsigned dividend of twice the base width by an unsigned divisor of the base width. The complete quotient and remainder come from a combinational array in one clock period. They are captured in an output register on the rising edge. With the default 16-bit base width, the dividend is 32 bits and the packed result word is 33 bits.

The result word has three fields:

- The remainder sits in the low half.
- The quotient sits above the remainder.
- A single status bit sits on top. It is set whenever the quotient cannot fit in the quotient field, which includes division by zero.

Because the block has no handshake, a new pair of operands can be presented every cycle. Each result appears one clock edge after its operands were sampled.

Top module: `udiv_single_cycle`

## Requirements
- R1: While the active-low reset is low at a rising clock edge, the result word becomes all zeros after that edge.
- R2: The result word has three fields, with W the divisor width (default 16):
  - bits [W-1:0] hold the remainder;
  - bits [2W-1:W] hold the quotient;
  - bit [2W] holds the overflow flag.
- R3: When the overflow flag is clear, quotient × divisor + remainder equals the dividend that was sampled at the previous rising edge.
- R4: When the overflow flag is clear, the remainder is strictly less than the divisor that was sampled at the previous rising edge.
- R5: The overflow flag is set exactly when the upper half of the sampled dividend (bits [2W-1:W]) is greater than or equal to the sampled divisor.
- R6: A divisor of zero always sets the overflow flag, whatever the dividend.
- R7: Whenever the overflow flag is set, the quotient and remainder fields are both zero.
- R8: Each rising edge outside reset registers the result for the operands present at that edge. Operands that change on every cycle give a correct result on every cycle.
- R9: The largest quotient that fits is produced correctly. This is the case where the upper dividend half equals divisor - 1, which yields a quotient of all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| dividend_i | input | 2W (32) | Unsigned dividend |
| divisor_i | input | W (16) | Unsigned divisor |
| result_o | output | 2W+1 (33) | {overflow flag, quotient, remainder} |

## Verification
The bench probes the boundary of the overflow test from both sides:

- Upper dividend half equal to the divisor. A comparator that used strict greater-than would miss this case and report a bogus quotient.
- Upper half equal to divisor - 1. A comparator that was too eager would flag this valid all-ones quotient.

Division by zero, with both zero and non-zero dividends, targets a design that treats a zero divisor as an ordinary value and returns garbage instead of the flag. Back-to-back vectors, including the extreme cases divisor = 1 and remainder = divisor - 1, expose the following faults:

- a stage that drops a quotient bit;
- a restore step that keeps the wrong partial remainder;
- fields swapped or shifted in the packed word.

// File: rtl/udiv_pkg.sv
// Package: udiv_pkg
// Shared constants and helpers for the single-cycle unsigned divider.
// Assumes: the base width is at least 2 bits.
package udiv_pkg;

    // Default base (divisor) width.
    localparam int unsigned UDIV_DEF_W = 16;

    // Bit position of the overflow flag in the packed result word.
    function automatic int unsigned ovf_pos(input int unsigned w);
        return 2 * w;
    endfunction

    // Total width of the packed result word.
    function automatic int unsigned result_width(input int unsigned w);
        return 2 * w + 1;
    endfunction

endpackage

// File: rtl/udiv_stage.sv
// Module: udiv_stage
// One compare-and-subtract step of a restoring division.
// The next dividend bit is shifted into the partial remainder, and the
// divisor is subtracted when it fits.
// Assumes: rem_in_i < divisor_i, so the new remainder also fits in W bits.
module udiv_stage #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] rem_in_i,
    input  logic         next_bit_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] rem_out_i,
    output logic         q_bit_o
);

    logic [W:0] trial;
    logic [W:0] diff;

    // Shift in the next bit, try the subtraction, and keep or restore.
    always_comb begin
        trial     = {rem_in_i, next_bit_i};
        diff      = trial - {1'b0, divisor_i};
        q_bit_o   = (trial >= {1'b0, divisor_i});
        rem_out_i = q_bit_o ? diff[W-1:0] : trial[W-1:0];
    end

endmodule

// File: rtl/udiv_array.sv
// Module: udiv_array
// A fully unrolled restoring divider built from W chained udiv_stage cells.
// Quotient bits are produced from the most significant to the least
// significant; the remainder is the residue left after the last stage.
// Assumes: the upper dividend half is below the divisor. When it is not,
// the outputs are meaningless and are masked by the caller.
module udiv_array #(
    parameter int unsigned W = 16
) (
    input  logic [2*W-1:0] dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic [W-1:0]   quotient_o,
    output logic [W-1:0]   remainder_o
);

    localparam int unsigned STAGES = W;

    logic [W-1:0] rem_chain [0:STAGES];

    // Seed the chain with the upper half of the dividend.
    assign rem_chain[0] = dividend_i[2*W-1:W];

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            udiv_stage #(.W(W)) stage_i (
                .rem_in_i   (rem_chain[k]),
                .next_bit_i (dividend_i[STAGES-1-k]),
                .divisor_i  (divisor_i),
                .rem_out_i  (rem_chain[k+1]),
                .q_bit_o    (quotient_o[STAGES-1-k])
            );
        end
    endgenerate

    assign remainder_o = rem_chain[STAGES];

endmodule

// File: rtl/udiv_ovf.sv
// Module: udiv_ovf
// Flags dividends whose quotient cannot fit in W bits.
// This is the case when the upper half is at least the divisor, which
// also covers a zero divisor.
// Assumes: unsigned operands.
module udiv_ovf #(
    parameter int unsigned W = 16
) (
    input  logic [2*W-1:0] dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic           ovf_o
);

    // Compare the upper dividend half against the divisor.
    always_comb begin
        ovf_o = (dividend_i[2*W-1:W] >= divisor_i);
    end

endmodule

// File: rtl/udiv_single_cycle.sv
// Module: udiv_single_cycle
// Top level of the single-cycle unsigned divider.
// It computes the quotient and remainder combinationally and registers a
// packed word {overflow, quotient, remainder} on every rising edge.
// Assumes: operands are stable around the rising edge; the reset is
// synchronous and active low.
module udiv_single_cycle
    import udiv_pkg::*;
#(
    parameter int unsigned W = UDIV_DEF_W
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [2*W-1:0]   dividend_i,
    input  logic [W-1:0]     divisor_i,
    output logic [2*W:0]     result_o
);

    localparam int unsigned RES_W   = result_width(W);
    localparam int unsigned OVF_BIT = ovf_pos(W);

    logic [W-1:0]   quot;
    logic [W-1:0]   rem;
    logic           ovf;
    logic [RES_W-1:0] next_result;

    udiv_array #(.W(W)) array_i (
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .quotient_o  (quot),
        .remainder_o (rem)
    );

    udiv_ovf #(.W(W)) ovf_i (
        .dividend_i (dividend_i),
        .divisor_i  (divisor_i),
        .ovf_o      (ovf)
    );

    // Pack the fields, forcing both data fields to zero on overflow.
    always_comb begin
        next_result          = '0;
        next_result[OVF_BIT] = ovf;
        if (!ovf) begin
            next_result[2*W-1:W] = quot;
            next_result[W-1:0]   = rem;
        end
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) result_o <= '0;
        else          result_o <= next_result;
    end

endmodule

// File: rtl/udiv_single_cycle_chk.sv
// Module: udiv_single_cycle_chk
// Property checker bound to udiv_single_cycle.
// It relates the registered result to the operands sampled one edge earlier.
// Assumes: the reset is held low at the first rising edge.
module udiv_single_cycle_chk #(
    parameter int unsigned W = 16
) (
    input logic           clk_i,
    input logic           rst_n_i,
    input logic [2*W-1:0] dividend_i,
    input logic [W-1:0]   divisor_i,
    input logic [2*W:0]   result_o
);

    logic           armed;
    logic [2*W-1:0] prev_dividend;
    logic [W-1:0]   prev_divisor;
    logic [2*W-1:0] recon;
    logic [W-1:0]   q_f;
    logic [W-1:0]   r_f;
    logic           f_f;

    // Track whether the previous edge was outside reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) armed <= 1'b0;
        else          armed <= 1'b1;
    end

    // Capture the operands seen at each edge.
    always_ff @(posedge clk_i) begin
        prev_dividend <= dividend_i;
        prev_divisor  <= divisor_i;
    end

    // Split the result word and rebuild the dividend from it.
    always_comb begin
        f_f   = result_o[2*W];
        q_f   = result_o[2*W-1:W];
        r_f   = result_o[W-1:0];
        recon = {{W{1'b0}}, q_f} * {{W{1'b0}}, prev_divisor} + {{W{1'b0}}, r_f};
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i)
        !rst_n_i |=> result_o == '0);

    // R3
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (armed && !f_f) |-> recon == prev_dividend);

    // R4
    rem_below_div_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (armed && !f_f) |-> r_f < prev_divisor);

    // R5
    overflow_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        armed |-> f_f == (prev_dividend[2*W-1:W] >= prev_divisor));

    // R6
    zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (armed && prev_divisor == '0) |-> f_f);

    // R7
    ovf_zero_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (armed && f_f) |-> (q_f == '0 && r_f == '0));

endmodule

bind udiv_single_cycle udiv_single_cycle_chk #(.W(W)) chk_i (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .result_o   (result_o)
);

// File: tb/udiv_single_cycle_tb_top.sv
// Bench for udiv_single_cycle.
// It walks a table of {quotient, divisor, remainder} triples back to back,
// then runs directed reset and overflow cases.
module udiv_single_cycle_tb_top;

    localparam int unsigned W  = 16;
    localparam int unsigned NV = 10;

    // Each entry is {quotient, divisor, remainder}, with remainder < divisor.
    localparam logic [3*W-1:0] VEC [0:NV-1] = '{
        {16'h0000, 16'h0001, 16'h0000},
        {16'h0001, 16'h0001, 16'h0000},
        {16'h1234, 16'h0056, 16'h0013},
        {16'hFFFF, 16'hFFFF, 16'hFFFE},
        {16'hFFFF, 16'h0001, 16'h0000},
        {16'h0007, 16'h0003, 16'h0002},
        {16'h8000, 16'h8000, 16'h7FFF},
        {16'hABCD, 16'h1357, 16'h0ACE},
        {16'h0000, 16'hFFFF, 16'hFFFE},
        {16'h0001, 16'h8001, 16'h8000}
    };

    logic           clk = 1'b0;
    logic           rst_n;
    logic [2*W-1:0] dividend;
    logic [W-1:0]   divisor;
    logic [2*W:0]   result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    udiv_single_cycle #(.W(W)) dut_i (
        .clk_i      (clk),
        .rst_n_i    (rst_n),
        .dividend_i (dividend),
        .divisor_i  (divisor),
        .result_o   (result)
    );

    task automatic check(input string req, input logic [2*W:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, result, exp);
        end
    endtask

    function automatic logic [2*W-1:0] build(input logic [3*W-1:0] v);
        return {{W{1'b0}}, v[3*W-1:2*W]} * {{W{1'b0}}, v[2*W-1:W]}
               + {{W{1'b0}}, v[W-1:0]};
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        dividend = 32'hFFFF_FFFF;
        divisor  = 16'h0003;
        @(negedge clk);
        // R1: the result is cleared in reset despite non-zero operands
        check("R1", '0);
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;

        // R2 R3 R4 R8: the table is walked back to back, one vector per cycle
        dividend = build(VEC[0]);
        divisor  = VEC[0][2*W-1:W];
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            check("R3", {1'b0, VEC[i][3*W-1:2*W], VEC[i][W-1:0]});
            if (i + 1 < NV) begin
                dividend = build(VEC[i+1]);
                divisor  = VEC[i+1][2*W-1:W];
            end
        end

        // R5 R7: the upper half equals the divisor, so the flag is set
        dividend = 32'h0005_0000;
        divisor  = 16'h0005;
        @(negedge clk);
        check("R5", {1'b1, 32'h0});

        // R9: the upper half is divisor-1, giving an all-ones quotient and remainder 4
        dividend = 32'h0004_FFFF;
        divisor  = 16'h0005;
        @(negedge clk);
        check("R9", {1'b0, 16'hFFFF, 16'h0004});

        // R7: a large overflow with both data fields zeroed
        dividend = 32'hFFFF_FFFF;
        divisor  = 16'h1234;
        @(negedge clk);
        check("R7", {1'b1, 32'h0});

        // R6: zero divided by zero
        dividend = 32'h0000_0000;
        divisor  = 16'h0000;
        @(negedge clk);
        check("R6", {1'b1, 32'h0});

        // R6: a non-zero dividend with a zero upper half, divided by zero
        dividend = 32'h0000_1234;
        @(negedge clk);
        check("R6", {1'b1, 32'h0});

        // R4: the remainder is just under the divisor
        dividend = 32'h0000_0009;
        divisor  = 16'h000A;
        @(negedge clk);
        check("R4", {1'b0, 16'h0000, 16'h0009});

        // R1: a mid-run reset clears a valid result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", {1'b0, 16'h0000, 16'h0009});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule